// File: doc/BRIEF.md
# Configurable-Width Single-Port Lookup Memory

An 8192-bit single-port memory. A 1024-entry by 8-bit storage array sits inside it, and a lane-mapping stage gives the user a choice of four shapes: 8192x1, 4096x2, 2048x4 or 1024x8. The address bus is 13 bits wide and both data buses are 8 bits wide for every shape. The upper ten address bits always pick the stored byte. Only as many low address bits as the chosen shape needs pick the lane inside that byte. Narrow writes update their lane by read-modify-write of the whole byte. Narrow reads are zero-extended to 8 bits.

Before normal use, a configuration phase fills the array from an image. One byte is written per accepted beat, starting at byte 0. A done flag rises once the last byte has been written. User accesses can be unregistered or pass through input registers on the input clock. The read result can bypass an output register or be captured by it. The output register runs on its own clock and has an asynchronous clear. A lock mode turns the block into a ROM or lookup table whose contents user writes cannot change.

Top module: `lutram_8k`

## Requirements
- R1: While `cfg_active` is high, each `in_clk` edge with `cfg_valid` high writes `cfg_data` into the next byte, starting at byte 0. `cfg_done` goes high in the cycle after byte 1023 is written and stays high until `rst`.
- R2: While `cfg_active` is high, the user write enable has no effect on the stored contents.
- R3: When `rom_mode` is high, user writes have no effect on the stored contents.
- R4: With `org_sel`=3 (x8), `addr[12:3]` selects the byte and a write stores all of `din`. `addr[2:0]` is ignored.
- R5: With `org_sel`=0 (x1), `addr[2:0]` selects bit lane n. A write changes only bit n, taken from `din[0]`. A read returns that bit on `dout[0]` with `dout[7:1]`=0.
- R6: With `org_sel`=1 (x2), `addr[2:1]` selects lane n, which is bits [2n+1:2n]. `addr[0]` is ignored. A write takes `din[1:0]`, and a read is zero-extended.
- R7: With `org_sel`=2 (x4), `addr[2]` selects a nibble. A write takes `din[3:0]`, and a read is zero-extended.
- R8: With `sync_mode`=0, read data follows `addr` with no clock. A write uses the port values at the rising edge of `in_clk`.
- R9: With `sync_mode`=1, `addr`, `din` and `we` are captured at an `in_clk` edge. The write is committed at the following edge. Read data reflects the most recently captured address.
- R10: With `oreg_en`=0, `dout` follows the read data combinationally.
- R11: With `oreg_en`=1, `dout` changes only on a rising edge of `out_clk`.
- R12: `oreg_arst` clears the output register to zero at once, with no clock edge needed.
- R13: `rst` (synchronous to `in_clk`) clears `cfg_done` and the load position and leaves the stored contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for the array, the input registers and the loader |
| out_clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, `in_clk` domain |
| oreg_arst | input | 1 | Asynchronous active-high clear of the output register |
| org_sel | input | 2 | Shape: 0=x1, 1=x2, 2=x4, 3=x8 |
| sync_mode | input | 1 | 1 sends user inputs through input registers |
| oreg_en | input | 1 | 1 takes `dout` from the output register |
| rom_mode | input | 1 | 1 blocks user writes |
| cfg_active | input | 1 | Configuration phase in progress |
| cfg_valid | input | 1 | Image byte valid this cycle |
| cfg_data | input | 8 | Image byte |
| cfg_done | output | 1 | All 1024 bytes loaded |
| addr | input | 13 | User address |
| din | input | 8 | User write data, right-aligned |
| we | input | 1 | User write enable |
| dout | output | 8 | Read data, zero-extended |

## Verification
The hardest case to reach from the ports is a user write attempted in the middle of the image load. The loader must keep its position and must not let the stray write reach a byte that is already loaded. The bench loads the full 1024-byte image. Halfway through, it drops `cfg_valid` for one cycle and drives a conflicting user write to an earlier byte. After the load ends, it reads that byte back. A second hard case is the sync-mode commit slot: the bench removes `we` before the commit edge and checks the old value between the capture edge and the commit edge. The output register is clocked by hand, so the asynchronous clear can be seen between clock edges.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  localparam int LR_ADDR_W = 13;
  localparam int LR_DATA_W = 8;

  typedef enum logic [1:0] {
    ORG_X1 = 2'd0,
    ORG_X2 = 2'd1,
    ORG_X4 = 2'd2,
    ORG_X8 = 2'd3
  } org_e;
endpackage

// File: rtl/lutram_array.sv
module lutram_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Clocked write, asynchronous read: maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lutram_loader.sv
module lutram_loader #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_active,
  input  logic          cfg_valid,
  input  logic [DW-1:0] cfg_data,
  output logic          ld_wr,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          done
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] ptr;

  assign ld_wr   = cfg_active && cfg_valid && !done;
  assign ld_addr = ptr;
  assign ld_data = cfg_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (ld_wr) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) done <= 1'b1;
    end
  end

  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ld_wr |=> (ptr == $past(ptr) + 1'b1));

  // R1
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_wr |=> $stable(ptr));
endmodule

// File: rtl/lutram_lane.sv
module lutram_lane #(
  parameter int DW    = 8,
  parameter int SEL_W = 3,
  parameter int ORG_W = 2
) (
  input  logic [ORG_W-1:0] org,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    old_byte,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    merged,
  output logic [DW-1:0]    rd_data
);
  int          lane_w;
  int          shift;
  logic [DW-1:0] field;
  logic [DW-1:0] place;

  always_comb begin
    lane_w = 1 << int'(org);
    shift  = (int'(sel) >> int'(org)) * lane_w;
    for (int i = 0; i < DW; i++) field[i] = (i < lane_w);
    place   = field << shift;
    merged  = (old_byte & ~place) | ((wr_data << shift) & place);
    rd_data = (old_byte >> shift) & field;
  end
endmodule

// File: rtl/lutram_outreg.sv
module lutram_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] hold;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) hold <= '0;
    else      hold <= d;
  end

  assign q = en ? hold : d;
endmodule

// File: rtl/lutram_8k.sv
module lutram_8k
  import lutram_pkg::*;
#(
  parameter int ADDR_W = LR_ADDR_W,
  parameter int DATA_W = LR_DATA_W
) (
  input  logic              in_clk,
  input  logic              out_clk,
  input  logic              rst,
  input  logic              oreg_arst,
  input  logic [1:0]        org_sel,
  input  logic              sync_mode,
  input  logic              oreg_en,
  input  logic              rom_mode,
  input  logic              cfg_active,
  input  logic              cfg_valid,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we,
  output logic [DATA_W-1:0] dout
);
  localparam int SEL_W   = $clog2(DATA_W);
  localparam int BYTE_AW = ADDR_W - SEL_W;

  // Input registers (used only in sync mode)
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              we_q;

  always_ff @(posedge in_clk) begin
    if (rst) begin
      addr_q <= '0;
      din_q  <= '0;
      we_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      din_q  <= din;
      we_q   <= we;
    end
  end

  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] eff_din;
  logic              eff_we;

  assign eff_addr = sync_mode ? addr_q : addr;
  assign eff_din  = sync_mode ? din_q  : din;
  assign eff_we   = sync_mode ? we_q   : we;

  // Loader
  logic               ld_wr;
  logic [BYTE_AW-1:0] ld_addr;
  logic [DATA_W-1:0]  ld_data;

  lutram_loader #(.AW(BYTE_AW), .DW(DATA_W)) u_loader (
    .clk       (in_clk),
    .rst       (rst),
    .cfg_active(cfg_active),
    .cfg_valid (cfg_valid),
    .cfg_data  (cfg_data),
    .ld_wr     (ld_wr),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .done      (cfg_done)
  );

  // Lane mapping
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_lane;

  lutram_lane #(.DW(DATA_W), .SEL_W(SEL_W), .ORG_W(2)) u_lane (
    .org     (org_sel),
    .sel     (eff_addr[SEL_W-1:0]),
    .old_byte(rd_byte),
    .wr_data (eff_din),
    .merged  (merged),
    .rd_data (rd_lane)
  );

  // Write arbitration: loader owns the array during configuration
  logic               user_wr;
  logic               arr_wr;
  logic [BYTE_AW-1:0] arr_waddr;
  logic [DATA_W-1:0]  arr_wdata;

  assign user_wr   = eff_we && !cfg_active && !rom_mode;
  assign arr_wr    = ld_wr || user_wr;
  assign arr_waddr = ld_wr ? ld_addr : eff_addr[ADDR_W-1:SEL_W];
  assign arr_wdata = ld_wr ? ld_data : merged;

  lutram_array #(.AW(BYTE_AW), .DW(DATA_W)) u_array (
    .clk  (in_clk),
    .wr   (arr_wr),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .raddr(eff_addr[ADDR_W-1:SEL_W]),
    .rdata(rd_byte)
  );

  lutram_outreg #(.DW(DATA_W)) u_outreg (
    .clk (out_clk),
    .arst(oreg_arst),
    .en  (oreg_en),
    .d   (rd_lane),
    .q   (dout)
  );

  // R2
  cfg_block_chk: assert property (@(posedge in_clk) disable iff (rst)
    (cfg_active && !ld_wr) |-> !arr_wr);

  // R3
  rom_lock_chk: assert property (@(posedge in_clk) disable iff (rst)
    (rom_mode && !cfg_active) |-> !arr_wr);

  // R5
  narrow_zext_chk: assert property (@(posedge in_clk) disable iff (rst)
    (org_sel == ORG_X1) |-> (rd_lane[DATA_W-1:1] == '0));

  // R1
  load_owner_chk: assert property (@(posedge in_clk) disable iff (rst)
    ld_wr |-> (arr_waddr == ld_addr && cfg_active));
endmodule

// File: tb/test_lutram_8k.sv
module test_lutram_8k;
  logic       in_clk = 1'b0;
  logic       out_clk = 1'b0;
  logic       rst = 1'b1;
  logic       oreg_arst = 1'b1;
  logic [1:0] org_sel = 2'd3;
  logic       sync_mode = 1'b0;
  logic       oreg_en = 1'b1;
  logic       rom_mode = 1'b0;
  logic       cfg_active = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       cfg_done;
  logic [12:0] addr = '0;
  logic [7:0] din = '0;
  logic       we = 1'b0;
  logic [7:0] dout;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] shadow [1024];

  lutram_8k i_lutram_8k (
    .in_clk(in_clk), .out_clk(out_clk), .rst(rst), .oreg_arst(oreg_arst),
    .org_sel(org_sel), .sync_mode(sync_mode), .oreg_en(oreg_en),
    .rom_mode(rom_mode), .cfg_active(cfg_active), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .cfg_done(cfg_done), .addr(addr), .din(din),
    .we(we), .dout(dout)
  );

  always #2 in_clk = ~in_clk;

  function automatic logic [7:0] img(int i);
    return 8'((i * 37 + (i >> 3) + 11) & 255);
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] org, logic [12:0] a);
    int w = 1 << org;
    int ln = int'(a[2:0]) / w;
    logic [7:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = shadow[a[12:3]][ln * w + b];
    return r;
  endfunction

  task automatic model_wr(logic [1:0] org, logic [12:0] a, logic [7:0] d);
    int w = 1 << org;
    int ln = int'(a[2:0]) / w;
    for (int b = 0; b < w; b++) shadow[a[12:3]][ln * w + b] = d[b];
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_oclk();
    out_clk = 1'b1; #1; out_clk = 1'b0; #1;
  endtask

  // One async-mode user write, then read back
  task automatic async_wr(logic [1:0] org, logic [12:0] a, logic [7:0] d);
    @(negedge in_clk);
    org_sel = org; addr = a; din = d; we = 1'b1;
    @(negedge in_clk);
    we = 1'b0;
  endtask

  task automatic read_chk(string req, logic [1:0] org, logic [12:0] a);
    @(negedge in_clk);
    org_sel = org; addr = a;
    #1;
    check(req, dout, exp_rd(org, a));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge in_clk);
    #1;
    check("R13 reset done", {7'd0, cfg_done}, 8'd0);
    check("R12 reset dout", dout, 8'd0);
    rst = 1'b0; oreg_arst = 1'b0; oreg_en = 1'b0;
  endtask

  task automatic t_config();
    @(negedge in_clk);
    cfg_active = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      if (i == 512) begin
        // R2: stray user write to an already loaded byte mid-load
        cfg_valid = 1'b0; org_sel = 2'd3; sync_mode = 1'b0;
        addr = 13'(5 << 3); din = ~img(5); we = 1'b1;
        @(negedge in_clk);
        we = 1'b0;
      end
      if (i == 1023) begin
        #1;
        check("R1 done before last", {7'd0, cfg_done}, 8'd0);
      end
      cfg_valid = 1'b1; cfg_data = img(i); shadow[i] = img(i);
      @(negedge in_clk);
    end
    cfg_valid = 1'b0;
    #1;
    check("R1 done after last", {7'd0, cfg_done}, 8'd1);
    cfg_active = 1'b0;
    read_chk("R1 byte0", 2'd3, 13'd0);
    read_chk("R1 byte1023", 2'd3, 13'h1FF8);
    read_chk("R1 byte700", 2'd3, 13'(700 << 3));
    read_chk("R2 byte5 untouched", 2'd3, 13'(5 << 3));
  endtask

  task automatic t_x8();
    async_wr(2'd3, 13'(20 << 3) | 13'd5, 8'hC3);
    model_wr(2'd3, 13'(20 << 3), 8'hC3);
    read_chk("R4 x8 write", 2'd3, 13'(20 << 3));
    read_chk("R4 x8 low bits ignored", 2'd3, 13'(20 << 3) | 13'd7);
  endtask

  task automatic t_x1();
    async_wr(2'd0, 13'(30 << 3) | 13'd6, 8'hFE);
    model_wr(2'd0, 13'(30 << 3) | 13'd6, 8'hFE);
    read_chk("R5 x1 bit6", 2'd0, 13'(30 << 3) | 13'd6);
    read_chk("R5 x1 neighbours", 2'd3, 13'(30 << 3));
    async_wr(2'd0, 13'(30 << 3) | 13'd1, 8'h01);
    model_wr(2'd0, 13'(30 << 3) | 13'd1, 8'h01);
    read_chk("R5 x1 bit1 zext", 2'd0, 13'(30 << 3) | 13'd1);
  endtask

  task automatic t_x2();
    async_wr(2'd1, 13'(31 << 3) | 13'd5, 8'hFD);
    model_wr(2'd1, 13'(31 << 3) | 13'd4, 8'hFD);
    read_chk("R6 x2 lane2", 2'd1, 13'(31 << 3) | 13'd4);
    read_chk("R6 x2 byte", 2'd3, 13'(31 << 3));
  endtask

  task automatic t_x4();
    async_wr(2'd2, 13'(32 << 3) | 13'd4, 8'h0A);
    model_wr(2'd2, 13'(32 << 3) | 13'd4, 8'h0A);
    read_chk("R7 x4 high nibble", 2'd2, 13'(32 << 3) | 13'd4);
    read_chk("R7 x4 byte", 2'd3, 13'(32 << 3));
  endtask

  task automatic t_async_read();
    @(negedge in_clk);
    org_sel = 2'd3; addr = 13'(100 << 3);
    #1;
    check("R8 comb read a", dout, shadow[100]);
    addr = 13'(101 << 3);
    #1;
    check("R8 comb read b", dout, shadow[101]);
  endtask

  task automatic t_sync();
    @(negedge in_clk);
    sync_mode = 1'b1; org_sel = 2'd3;
    addr = 13'(40 << 3); din = 8'h77; we = 1'b1;
    @(negedge in_clk);
    we = 1'b0;
    #1;
    check("R9 not yet committed", dout, shadow[40]);
    model_wr(2'd3, 13'(40 << 3), 8'h77);
    @(negedge in_clk);
    #1;
    check("R9 committed", dout, 8'h77);
    addr = 13'(41 << 3);
    #1;
    check("R9 address registered", dout, 8'h77);
    @(negedge in_clk);
    #1;
    check("R9 new address", dout, shadow[41]);
    sync_mode = 1'b0;
  endtask

  task automatic t_rom();
    @(negedge in_clk);
    rom_mode = 1'b1;
    async_wr(2'd3, 13'(9 << 3), ~shadow[9]);
    read_chk("R3 rom write blocked", 2'd3, 13'(9 << 3));
    rom_mode = 1'b0;
  endtask

  task automatic t_oreg();
    @(negedge in_clk);
    org_sel = 2'd3; addr = 13'(50 << 3); oreg_en = 1'b1;
    pulse_oclk();
    check("R11 captured", dout, shadow[50]);
    addr = 13'(51 << 3);
    #1;
    check("R11 held", dout, shadow[50]);
    pulse_oclk();
    check("R11 next", dout, shadow[51]);
    oreg_arst = 1'b1;
    #1;
    check("R12 async clear", dout, 8'd0);
    oreg_arst = 1'b0;
    #1;
    check("R12 stays clear", dout, 8'd0);
    pulse_oclk();
    check("R11 after clear", dout, shadow[51]);
    oreg_en = 1'b0;
    addr = 13'(52 << 3);
    #1;
    check("R10 bypass", dout, shadow[52]);
  endtask

  task automatic t_rst_keep();
    @(negedge in_clk);
    rst = 1'b1;
    repeat (2) @(negedge in_clk);
    rst = 1'b0;
    #1;
    check("R13 done cleared", {7'd0, cfg_done}, 8'd0);
    read_chk("R13 contents kept", 2'd3, 13'(700 << 3));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_config();
        t_x8();
        t_x1();
        t_x2();
        t_x4();
        t_async_read();
        t_sync();
        t_rom();
        t_oreg();
        t_rst_keep();
      end
      begin
        repeat (100000) @(posedge in_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule